// File: doc/BRIEF.md
# SPI Serial EEPROM Slave

This block is the digital control side of a byte-wide serial memory that sits on an SPI bus as a slave. The host pulls chip select low and sends an 8-bit opcode, then a 16-bit address, both most significant bit first. Address bits above the array's own width are ignored. A read instruction then streams bytes out of consecutive locations for as long as the host keeps clocking. The read address wraps from the top of the array back to zero. A write instruction takes one or more data bytes. These are collected in a page buffer, with the offset wrapping inside the addressed page.

A write is committed only when chip select returns high exactly on a data byte boundary, after at least one complete data byte. That edge starts a self-timed busy period. During it the buffered bytes are copied into the array and `wip` reads 1. While `wip` is high, every new instruction is refused.

The serial pins are sampled in the system clock domain through a configurable synchronizer. The bus runs in SPI mode 0: input is taken on the serial clock rising edge and output changes on the falling edge. The array depth is `2**ADDR_W` bytes; `ADDR_W = 13` gives the 8K x 8 organisation.

Top module: `spi_ee_slave`

## Requirements
- R1: Opcode 8'h03 selects read and 8'h02 selects write; both are followed by a 16-bit address sent MSB first, of which only the low ADDR_W bits are used.
- R2: After the last address bit of a read, the byte at the addressed location is driven on `miso`, MSB first. Its first bit appears after the next serial clock falling edge. Following bytes come from increasing addresses, and `miso_oe` is 1 throughout this data phase.
- R3: During a read, the location after address 2**ADDR_W-1 is address 0.
- R4: Chip select going high ends a read at any bit, including mid-byte; `miso_oe` returns to 0 within a few system clocks.
- R5: Any instruction received while `wip` is 1 is ignored: a read drives nothing (`miso_oe` stays 0).
- R6: Write data bytes go to consecutive offsets within the addressed PAGE_BYTES page. The offset wraps from the page's last byte to its first, and a later byte overwrites an earlier one at the same location.
- R7: A write is committed only if chip select rises at a byte boundary after at least one complete data byte. Otherwise the array is unchanged and `wip` stays 0.
- R8: A committed write sets `wip` to 1 for exactly WRITE_CYCLES system clocks, after which it returns to 0 and the data is readable.
- R9: `miso_oe` is 0 at all times outside the data phase of an accepted read, in particular throughout a write instruction.
- R10: An unrecognised opcode is ignored: no output is driven and no write starts for the rest of that chip-select period.
- R11: After reset, `wip` and `miso_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, idle low |
| mosi | input | 1 | Serial data into the slave |
| miso | output | 1 | Serial data out of the slave |
| miso_oe | output | 1 | Drive enable for `miso` |
| wip | output | 1 | Write cycle in progress |

## Verification
The bench builds the block with ADDR_W = 8 and PAGE_BYTES = 16, so the whole 256-byte array can be filled with sixteen page writes. With that size, the wrap from the last address to zero can be crossed by a short read. WRITE_CYCLES is 600, which is longer than a complete read instruction at the bench's serial rate, so a read can be issued and finished entirely inside a busy period. Two synchronizer stages are kept so that the serial edge latency the design must absorb is the realistic one.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
   localparam logic [7:0] OP_READ  = 8'h03;
   localparam logic [7:0] OP_WRITE = 8'h02;

   typedef enum logic [2:0] {
      ST_CMD,
      ST_ADDR,
      ST_READ,
      ST_WRITE,
      ST_SKIP
   } ee_state_t;
endpackage

// File: rtl/spi_ee_rx.sv
module spi_ee_rx #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       sck,
   input  logic       mosi,
   output logic       sel,
   output logic       sck_rise,
   output logic       sck_fall,
   output logic       cs_rise,
   output logic       at_boundary,
   output logic       byte_done,
   output logic [7:0] byte_val
);
   logic [2:0] raw, synced;
   assign raw = {cs_n, sck, mosi};

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign synced = raw;
      end else begin : g_sync
         logic [2:0] stage [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC_STAGES; i++) stage[i] <= 3'b100;
            end else begin
               stage[0] <= raw;
               for (int i = 1; i < SYNC_STAGES; i++) stage[i] <= stage[i-1];
            end
         end
         assign synced = stage[SYNC_STAGES-1];
      end
   endgenerate

   logic       cs_q, sck_q;
   logic [2:0] bitcnt;
   logic [6:0] shreg;

   assign sel         = ~synced[2];
   assign sck_rise    = sel & synced[1] & ~sck_q;
   assign sck_fall    = sel & ~synced[1] & sck_q;
   assign cs_rise     = synced[2] & ~cs_q;
   assign at_boundary = (bitcnt == 3'd0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q      <= 1'b1;
         sck_q     <= 1'b0;
         bitcnt    <= '0;
         shreg     <= '0;
         byte_done <= 1'b0;
         byte_val  <= '0;
      end else begin
         cs_q      <= synced[2];
         sck_q     <= synced[1];
         byte_done <= 1'b0;
         if (!sel) begin
            bitcnt <= '0;
         end else if (sck_rise) begin
            shreg  <= {shreg[5:0], synced[0]};
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
               byte_done <= 1'b1;
               byte_val  <= {shreg, synced[0]};
            end
         end
      end
   end

   p_byte_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |=> !byte_done);
   p_deselect_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> at_boundary);
endmodule

// File: rtl/spi_ee_pagebuf.sv
module spi_ee_pagebuf #(
   parameter int PAGE_BYTES = 32,
   parameter int PG_W       = $clog2(PAGE_BYTES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [PG_W-1:0] wr_off,
   input  logic [7:0]      wr_data,
   input  logic            drop,
   input  logic            commit,
   output logic            mem_we,
   output logic [PG_W-1:0] mem_off,
   output logic [7:0]      mem_data,
   output logic            walking
);
   logic [7:0]            slot [PAGE_BYTES];
   logic [PAGE_BYTES-1:0] valid;
   logic [PG_W-1:0]       idx;

   always_ff @(posedge clk) begin
      if (wr_en) slot[wr_off] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid   <= '0;
         walking <= 1'b0;
         idx     <= '0;
      end else if (commit) begin
         walking <= 1'b1;
         idx     <= '0;
      end else if (walking) begin
         idx <= idx + 1'b1;
         if (idx == PG_W'(PAGE_BYTES - 1)) begin
            walking <= 1'b0;
            valid   <= '0;
         end
      end else if (drop) begin
         valid <= '0;
      end else if (wr_en) begin
         valid[wr_off] <= 1'b1;
      end
   end

   assign mem_we   = walking & valid[idx];
   assign mem_off  = idx;
   assign mem_data = slot[idx];

   p_walk_no_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
      walking |-> !wr_en);
   p_commit_walks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> walking);
endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array #(
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [7:0]        wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [7:0]        rdata
);
   localparam int DEPTH = 2 ** ADDR_W;
   logic [7:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end
   assign rdata = cells[raddr];
endmodule

// File: rtl/spi_ee_slave.sv
module spi_ee_slave
   import spi_ee_pkg::*;
#(
   parameter int ADDR_W       = 11,
   parameter int PAGE_BYTES   = 32,
   parameter int WRITE_CYCLES = 4096,
   parameter int SYNC_STAGES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sck,
   input  logic mosi,
   output logic miso,
   output logic miso_oe,
   output logic wip
);
   localparam int PG_W  = $clog2(PAGE_BYTES);
   localparam int BASE_W = ADDR_W - PG_W;
   localparam int TMR_W = $clog2(WRITE_CYCLES);

   initial begin
      assert (PAGE_BYTES >= 2 && (PAGE_BYTES & (PAGE_BYTES - 1)) == 0)
         else $error("PAGE_BYTES must be a power of two of at least 2");
      assert (ADDR_W > PG_W && ADDR_W <= 16)
         else $error("ADDR_W must exceed the page offset width and fit 16 bits");
      assert (WRITE_CYCLES >= PAGE_BYTES)
         else $error("WRITE_CYCLES must cover one pass over the page buffer");
   end

   logic       sel, sck_rise, sck_fall, cs_rise, at_boundary, byte_done;
   logic [7:0] byte_val;

   spi_ee_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk, .rst_n, .cs_n, .sck, .mosi,
      .sel, .sck_rise, .sck_fall, .cs_rise, .at_boundary,
      .byte_done, .byte_val
   );

   ee_state_t         state;
   logic              is_wr, addr_cnt, have_data;
   logic [7:0]        addr_hi;
   logic [ADDR_W-1:0] rd_ptr;
   logic [BASE_W-1:0] wr_base;
   logic [PG_W-1:0]   wr_off;
   logic [TMR_W-1:0]  timer;
   logic [7:0]        tx;
   logic [15:0]       full_addr;

   logic            wr_byte, commit, drop, mem_we, walking;
   logic [PG_W-1:0] mem_off;
   logic [7:0]      mem_data, rd_data;

   assign full_addr = {addr_hi, byte_val};
   assign wr_byte   = byte_done & (state == ST_WRITE);
   assign commit    = cs_rise & (state == ST_WRITE) & have_data & at_boundary;
   assign drop      = cs_rise & (state == ST_WRITE) & ~commit;

   spi_ee_pagebuf #(.PAGE_BYTES(PAGE_BYTES), .PG_W(PG_W)) u_page (
      .clk, .rst_n, .wr_en(wr_byte), .wr_off, .wr_data(byte_val),
      .drop, .commit, .mem_we, .mem_off, .mem_data, .walking
   );

   spi_ee_array #(.ADDR_W(ADDR_W)) u_array (
      .clk, .we(mem_we), .waddr({wr_base, mem_off}), .wdata(mem_data),
      .raddr(rd_ptr), .rdata(rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wip   <= 1'b0;
         timer <= '0;
      end else if (commit) begin
         wip   <= 1'b1;
         timer <= '0;
      end else if (wip) begin
         if (timer == TMR_W'(WRITE_CYCLES - 1)) wip <= 1'b0;
         else timer <= timer + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_CMD;
         is_wr     <= 1'b0;
         addr_cnt  <= 1'b0;
         addr_hi   <= '0;
         have_data <= 1'b0;
         rd_ptr    <= '0;
         wr_base   <= '0;
         wr_off    <= '0;
         tx        <= '0;
         miso_oe   <= 1'b0;
      end else if (!sel) begin
         state     <= ST_CMD;
         have_data <= 1'b0;
         miso_oe   <= 1'b0;
      end else begin
         if (byte_done) begin
            case (state)
               ST_CMD: begin
                  if (!wip && (byte_val == OP_READ || byte_val == OP_WRITE)) begin
                     is_wr    <= (byte_val == OP_WRITE);
                     addr_cnt <= 1'b0;
                     state    <= ST_ADDR;
                  end else begin
                     state <= ST_SKIP;
                  end
               end
               ST_ADDR: begin
                  if (!addr_cnt) begin
                     addr_hi  <= byte_val;
                     addr_cnt <= 1'b1;
                  end else begin
                     rd_ptr  <= full_addr[ADDR_W-1:0];
                     wr_base <= full_addr[ADDR_W-1:PG_W];
                     wr_off  <= full_addr[PG_W-1:0];
                     state   <= is_wr ? ST_WRITE : ST_READ;
                  end
               end
               ST_WRITE: begin
                  wr_off    <= wr_off + 1'b1;
                  have_data <= 1'b1;
               end
               default: ;
            endcase
         end
         if (state == ST_READ && sck_fall) begin
            if (at_boundary) begin
               tx      <= rd_data;
               rd_ptr  <= rd_ptr + 1'b1;
               miso_oe <= 1'b1;
            end else begin
               tx <= {tx[6:0], 1'b0};
            end
         end
      end
   end

   assign miso = tx[7];

   p_oe_in_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      miso_oe |-> (state == ST_READ));
   p_no_oe_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(wip && miso_oe));
   p_wip_from_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wip) |-> $past(cs_rise));
   p_wip_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wip && timer != TMR_W'(WRITE_CYCLES - 1)) |=> wip);
   p_array_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> wip);
endmodule

// File: tb/spi_ee_slave_test.sv
module spi_ee_slave_test;
   localparam int CLK_P  = 10;
   localparam int HALF   = 6;
   localparam int AW     = 8;
   localparam int PAGE   = 16;
   localparam int WC     = 600;
   localparam int DEPTH  = 2 ** AW;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
   logic miso, miso_oe, wip;

   spi_ee_slave #(.ADDR_W(AW), .PAGE_BYTES(PAGE), .WRITE_CYCLES(WC), .SYNC_STAGES(2)) uut (
      .clk, .rst_n, .cs_n, .sck, .mosi, .miso, .miso_oe, .wip
   );

   always #(CLK_P/2) clk = ~clk;

   int checks = 0, errors = 0;
   logic [7:0] model [DEPTH];
   logic [7:0] exp_q [$];
   string      cur_req = "R2";
   bit         mon_on = 0, oe_guard = 0, oe_bad = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: pops expected bytes as the read data phase produces them
   initial begin
      int bitc = 0;
      logic [7:0] rsh = '0;
      bit oe_all = 1;
      forever begin
         @(negedge cs_n or posedge sck);
         if (!sck) begin
            bitc = 0; oe_all = 1;
         end else if (mon_on) begin
            bitc++;
            if (bitc > 24) begin
               rsh = {rsh[6:0], miso};
               if (!miso_oe) oe_all = 0;
               if ((bitc - 24) % 8 == 0) begin
                  if (exp_q.size() == 0) begin
                     check(0, cur_req, rsh, 0);
                  end else begin
                     logic [7:0] e;
                     e = exp_q.pop_front();
                     check(rsh == e && oe_all, cur_req, {oe_all, rsh}, {1'b1, e});
                  end
                  oe_all = 1;
               end
            end
         end
      end
   end

   always @(negedge clk) if (oe_guard && miso_oe) oe_bad = 1;

   task automatic spi_bit(input logic b);
      @(negedge clk) mosi = b;
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
   endtask

   task automatic spi_byte(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) spi_bit(b[i]);
   endtask

   task automatic sel_on();
      @(negedge clk) cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic sel_off();
      @(negedge clk) cs_n = 1'b1;
   endtask

   // write instruction; commit_exp selects whether the model and wip timing are checked
   task automatic do_write(input logic [15:0] a, input logic [7:0] d [$], input int extra_bits,
                           input bit commit_exp, input bit wait_done, input string req);
      logic [AW-1:0] loc;
      int cnt;
      oe_guard = 1; oe_bad = 0;
      sel_on();
      spi_byte(8'h02);
      spi_byte(a[15:8]);
      spi_byte(a[7:0]);
      foreach (d[i]) spi_byte(d[i]);
      for (int i = 0; i < extra_bits; i++) spi_bit(1'b1);
      sel_off();
      oe_guard = 0;
      check(!oe_bad, "R9", oe_bad, 0);
      if (commit_exp) begin
         loc = a[AW-1:0];
         foreach (d[i]) begin
            model[loc] = d[i];
            loc[$clog2(PAGE)-1:0] = loc[$clog2(PAGE)-1:0] + 1'b1;
         end
         cnt = 0;
         while (!wip && cnt < 20) begin @(negedge clk); cnt++; end
         if (wait_done) begin
            cnt = 0;
            while (wip) begin cnt++; @(negedge clk); end
            check(cnt == WC, "R8", cnt, WC);
         end else begin
            check(wip, "R8", wip, 1);
         end
      end else begin
         cnt = 0;
         for (int i = 0; i < 20; i++) begin @(negedge clk); if (wip) cnt++; end
         check(cnt == 0, req, cnt, 0);
      end
      repeat (HALF) @(negedge clk);
   endtask

   task automatic do_read(input logic [15:0] a, input int n, input int extra_bits, input string req);
      cur_req = req;
      for (int i = 0; i < n; i++) exp_q.push_back(model[(int'(a[AW-1:0]) + i) % DEPTH]);
      mon_on = 1;
      sel_on();
      spi_byte(8'h03);
      spi_byte(a[15:8]);
      spi_byte(a[7:0]);
      for (int i = 0; i < n * 8 + extra_bits; i++) spi_bit(1'b0);
      sel_off();
      mon_on = 0;
      repeat (HALF) @(negedge clk);
      check(exp_q.size() == 0, req, exp_q.size(), 0);
      exp_q.delete();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      check(0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] pg [$];
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: reset state
      check(wip == 1'b0 && miso_oe == 1'b0, "R11", {wip, miso_oe}, 0);

      // fill the array page by page (R6, R8)
      for (int p = 0; p < DEPTH / PAGE; p++) begin
         pg.delete();
         for (int i = 0; i < PAGE; i++) pg.push_back(8'((p * PAGE + i) ^ 8'h5A));
         do_write(16'(p * PAGE), pg, 0, 1, 1, "R6");
      end

      // R1 R2: high address bits ignored, consecutive bytes
      do_read(16'hAB10, 6, 0, "R1");
      do_read(16'h0033, 3, 0, "R2");
      // R3: wrap from the top of the array to zero
      do_read(16'h00FC, 8, 0, "R3");

      // R6: offset wraps inside the page (0x2E -> 0x2F, 0x20, 0x21)
      do_write(16'h002E, '{8'hA1, 8'hA2, 8'hA3, 8'hA4}, 0, 1, 1, "R6");
      do_read(16'h0020, 16, 0, "R6");
      // R6: more bytes than a page overwrite the first ones
      pg.delete();
      for (int i = 0; i < PAGE + 2; i++) pg.push_back(8'(8'hC0 + i));
      do_write(16'h0030, pg, 0, 1, 1, "R6");
      do_read(16'h0030, 16, 0, "R6");

      // R7: chip select rises mid-byte, and before any data byte
      do_write(16'h0050, '{8'h11, 8'h22}, 3, 0, 0, "R7");
      do_write(16'h0050, '{}, 0, 0, 0, "R7");
      do_write(16'h0050, '{}, 5, 0, 0, "R7");
      do_read(16'h0050, 4, 0, "R7");

      // R5: read issued during the busy period drives nothing
      do_write(16'h0060, '{8'h77, 8'h78}, 0, 1, 0, "R8");
      oe_guard = 1; oe_bad = 0;
      sel_on();
      spi_byte(8'h03); spi_byte(8'h00); spi_byte(8'h60);
      for (int i = 0; i < 16; i++) spi_bit(1'b0);
      sel_off();
      oe_guard = 0;
      check(!oe_bad, "R5", oe_bad, 0);
      while (wip) @(negedge clk);
      do_read(16'h0060, 2, 0, "R8");

      // R4: read cut mid-byte, then a fresh read
      do_read(16'h0070, 1, 4, "R4");
      repeat (6) @(negedge clk);
      check(miso_oe == 1'b0, "R4", miso_oe, 0);
      do_read(16'h0071, 2, 0, "R4");

      // R10: unknown opcode
      oe_guard = 1; oe_bad = 0;
      sel_on();
      spi_byte(8'h05); spi_byte(8'h00); spi_byte(8'h10);
      for (int i = 0; i < 16; i++) spi_bit(1'b0);
      sel_off();
      oe_guard = 0;
      repeat (20) @(negedge clk);
      check(!oe_bad && !wip, "R10", {oe_bad, wip}, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule